// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills an address translation cache after a lookup miss. It takes the virtual page number of the missing access and the physical base address of the current first-level table. It then reads the page table in memory with plain physical reads, one at a time. The first read fetches the first-level entry. Unless that entry ends the walk, a second read fetches the second-level entry. The result is a physical page number plus attribute bits to be written into the translation cache, or a page-fault indication that the fault handler acts on.

A first-level entry may map a large page directly. In that case the walk stops after one read, and the second-level index bits of the virtual address pass straight into the low half of the returned page number. An entry that is invalid, or whose page is not resident in primary memory, ends the walk with a fault and no translation.

The memory port sends a request as a single-cycle pulse. The response may come back after any number of cycles, at least one. Only one walk runs at a time. The block reports the outcome for exactly one cycle and then becomes free again.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req_valid` are low.
- R2: A miss accepted while idle produces, on the next cycle, a one-cycle read at `root_base + miss_vpn[19:10]*4`.
- R3: When the first-level entry is valid, resident and not a leaf, a second one-cycle read follows its response, at `{entry[31:12], 12'h000} + miss_vpn[9:0]*4`.
- R4: Entry format: bit 0 valid, bit 1 resident, bit 2 leaf (large page, meaningful at the first level only), bits 11:3 attributes (bit 3 read, bit 4 write, bit 5 dirty, the others passed through), bits 31:12 page number or next-table base. A second-level entry that is valid and resident returns `done_ppn = entry[31:12]` and `done_attr = entry[11:3]`, with its leaf bit ignored.
- R5: A first-level entry that is valid, resident and leaf ends the walk after one read, with `done_large` = 1, `done_ppn = {entry[31:22], miss_vpn[9:0]}` and `done_attr = entry[11:3]`.
- R6: An entry with valid = 0 or resident = 0, at either level, ends the walk at once with `done_fault` = 1 and `done_ppn`, `done_attr` and `done_large` all zero. No further read follows.
- R7: `busy` is high from the cycle after a miss is accepted through the cycle in which `done` is high. `done` lasts one cycle. Misses presented while busy are ignored.
- R8: A memory response that arrives while no read is outstanding changes nothing.
- R9: `done_vpn` equals the page number of the miss that started the walk.
- R10: At most one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss present; taken only while idle |
| miss_vpn | input | 20 | Virtual page number of the missing access |
| root_base | input | 32 | Physical base of the current first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle physical read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_resp_valid | input | 1 | Read data returned |
| mem_resp_data | input | 32 | Page table entry read from memory |
| done | output | 1 | Walk outcome valid, one cycle |
| done_fault | output | 1 | Walk ended in a page fault |
| done_large | output | 1 | Translation is a large page |
| done_vpn | output | 20 | Virtual page number being refilled |
| done_ppn | output | 20 | Physical page number of the translation |
| done_attr | output | 9 | Attribute bits of the translation |

## Verification
The bound checker checks on every cycle that a request lasts one cycle, that no request is issued while another is outstanding, that a result lasts one cycle and carries the page number of the miss that started it, and that fault and large-page results are well formed. Only the bench scenarios can show that the entry addresses are correct at both levels, that the walk stops at the right level for each kind of entry, that the returned page number and attributes are right, and that stray responses and misses arriving while busy have no effect. The bench builds random page-table entries and compares each outcome with an independent model of the walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int PA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          miss_valid,
  input  logic [L1_BITS+L2_BITS-1:0]    miss_vpn,
  input  logic [PA_W-1:0]               root_base,
  output logic                          busy,
  output logic                          mem_req_valid,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_resp_valid,
  input  logic [PA_W-1:0]               mem_resp_data,
  output logic                          done,
  output logic                          done_fault,
  output logic                          done_large,
  output logic [L1_BITS+L2_BITS-1:0]    done_vpn,
  output logic [PA_W-OFF_BITS-1:0]      done_ppn,
  output logic [OFF_BITS-4:0]           done_attr
);
  localparam int VPN_W  = L1_BITS + L2_BITS;
  localparam int PPN_W  = PA_W - OFF_BITS;
  localparam int ATTR_W = OFF_BITS - 3;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } st_t;

  st_t               st;
  logic [VPN_W-1:0]  vpn_q;
  logic [PA_W-1:0]   root_q;
  logic [PA_W-1:0]   l2base_q;
  logic              res_fault, res_large;
  logic [PPN_W-1:0]  res_ppn;
  logic [ATTR_W-1:0] res_attr;

  logic [L1_BITS-1:0] idx1;
  logic [L2_BITS-1:0] idx2;
  logic               pte_ok, pte_leaf;
  logic [PPN_W-1:0]   pte_pn;
  logic [ATTR_W-1:0]  pte_attr;

  assign idx1     = vpn_q[VPN_W-1 -: L1_BITS];
  assign idx2     = vpn_q[L2_BITS-1:0];
  assign pte_ok   = mem_resp_data[0] & mem_resp_data[1];
  assign pte_leaf = mem_resp_data[2];
  assign pte_attr = mem_resp_data[OFF_BITS-1:3];
  assign pte_pn   = mem_resp_data[PA_W-1:OFF_BITS];

  assign busy          = (st != S_IDLE);
  assign done          = (st == S_DONE);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_req_addr  = (st == S_L2_REQ)
                       ? l2base_q + {{(PA_W-L2_BITS-2){1'b0}}, idx2, 2'b00}
                       : root_q   + {{(PA_W-L1_BITS-2){1'b0}}, idx1, 2'b00};

  assign done_fault = res_fault;
  assign done_large = res_large;
  assign done_vpn   = vpn_q;
  assign done_ppn   = res_ppn;
  assign done_attr  = res_attr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vpn_q     <= '0;
      root_q    <= '0;
      l2base_q  <= '0;
      res_fault <= 1'b0;
      res_large <= 1'b0;
      res_ppn   <= '0;
      res_attr  <= '0;
    end else begin
      case (st)
        S_IDLE: if (miss_valid) begin
          vpn_q  <= miss_vpn;
          root_q <= root_base;
          st     <= S_L1_REQ;
        end
        S_L1_REQ: st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_resp_valid) begin
          if (!pte_ok) begin
            res_fault <= 1'b1;
            res_large <= 1'b0;
            res_ppn   <= '0;
            res_attr  <= '0;
            st        <= S_DONE;
          end else if (pte_leaf) begin
            res_fault <= 1'b0;
            res_large <= 1'b1;
            res_ppn   <= {pte_pn[PPN_W-1:L2_BITS], idx2};
            res_attr  <= pte_attr;
            st        <= S_DONE;
          end else begin
            l2base_q  <= {pte_pn, {OFF_BITS{1'b0}}};
            st        <= S_L2_REQ;
          end
        end
        S_L2_REQ: st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_resp_valid) begin
          res_fault <= !pte_ok;
          res_large <= 1'b0;
          res_ppn   <= pte_ok ? pte_pn : '0;
          res_attr  <= pte_ok ? pte_attr : '0;
          st        <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int PA_W     = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        miss_valid,
  input logic [L1_BITS+L2_BITS-1:0]  miss_vpn,
  input logic                        busy,
  input logic                        mem_req_valid,
  input logic                        mem_resp_valid,
  input logic                        done,
  input logic                        done_fault,
  input logic                        done_large,
  input logic [L1_BITS+L2_BITS-1:0]  done_vpn,
  input logic [PA_W-OFF_BITS-1:0]    done_ppn,
  input logic [OFF_BITS-4:0]         done_attr
);
  logic                       outst;
  logic [L1_BITS+L2_BITS-1:0] vpn_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst    <= 1'b0;
      vpn_seen <= '0;
    end else begin
      if (mem_req_valid)       outst <= 1'b1;
      else if (mem_resp_valid) outst <= 1'b0;
      if (miss_valid && !busy) vpn_seen <= miss_vpn;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !mem_req_valid));
  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !busy) |=> busy);
  // R9
  vpn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_vpn == vpn_seen));
  // R5
  large_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_large) |-> (!done_fault && done_ppn[L2_BITS-1:0] == vpn_seen[L2_BITS-1:0]));
  // R6
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_ppn == '0 && done_attr == '0 && !done_large));
endmodule

bind pt_walker pt_walker_chk #(
  .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
  .busy(busy), .mem_req_valid(mem_req_valid), .mem_resp_valid(mem_resp_valid),
  .done(done), .done_fault(done_fault), .done_large(done_large),
  .done_vpn(done_vpn), .done_ppn(done_ppn), .done_attr(done_attr)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [19:0] miss_vpn = '0;
  logic [31:0] root_base = '0;
  logic        busy, mem_req_valid, mem_resp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_resp_data = '0;
  logic        done, done_fault, done_large;
  logic [19:0] done_vpn, done_ppn;
  logic [8:0]  done_attr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
    .root_base(root_base), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .done(done), .done_fault(done_fault),
    .done_large(done_large), .done_vpn(done_vpn), .done_ppn(done_ppn),
    .done_attr(done_attr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {fault, large, nreq[1:0], attr[8:0], ppn[19:0]}
  function automatic logic [32:0] model(input logic [19:0] vpn, input logic [31:0] e1, input logic [31:0] e2);
    if (!(e1[0] && e1[1]))  return {1'b1, 1'b0, 2'd1, 9'd0, 20'd0};
    if (e1[2])              return {1'b0, 1'b1, 2'd1, e1[11:3], e1[31:22], vpn[9:0]};
    if (!(e2[0] && e2[1]))  return {1'b1, 1'b0, 2'd2, 9'd0, 20'd0};
    return {1'b0, 1'b0, 2'd2, e2[11:3], e2[31:12]};
  endfunction

  task automatic walk(input logic [19:0] vpn, input logic [31:0] root,
                      input logic [31:0] e1, input logic [31:0] e2, input bit poke);
    logic [32:0] exp;
    logic [31:0] a1, a2;
    int nreq, pending;
    bit got;
    exp = model(vpn, e1, e2);
    a1 = root + {20'd0, vpn[19:10], 2'b00};
    a2 = {e1[31:12], 12'h000} + {20'd0, vpn[9:0], 2'b00};
    nreq = 0; pending = 0; got = 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_vpn = vpn; root_base = root;
    @(negedge clk);
    miss_valid = poke; miss_vpn = ~vpn; root_base = ~root;
    chk(busy === 1'b1, "R7 busy after accept", {31'd0, busy}, 32'd1);
    for (int c = 0; c < 200 && !got; c++) begin
      mem_resp_valid = 1'b0;
      if (done) begin
        got = 1;
        miss_valid = 1'b0;
        chk(done_fault === exp[32], "R6 fault flag", {31'd0, done_fault}, {31'd0, exp[32]});
        chk(done_large === exp[31], "R5 large flag", {31'd0, done_large}, {31'd0, exp[31]});
        chk(nreq == int'(exp[30:29]), "R5 read count", nreq, {30'd0, exp[30:29]});
        chk(done_attr === exp[28:20], "R4 attributes", {23'd0, done_attr}, {23'd0, exp[28:20]});
        chk(done_ppn === exp[19:0], "R4 page number", {12'd0, done_ppn}, {12'd0, exp[19:0]});
        chk(done_vpn === vpn, "R9 vpn", {12'd0, done_vpn}, {12'd0, vpn});
        if (poke) begin
          mem_resp_valid = 1'b1;
          mem_resp_data = $urandom;
        end
      end else if (mem_req_valid) begin
        nreq++;
        chk(pending == 0, "R10 single outstanding", pending, 0);
        if (nreq == 1) chk(mem_req_addr === a1, "R2 level-1 address", mem_req_addr, a1);
        else           chk(mem_req_addr === a2, "R3 level-2 address", mem_req_addr, a2);
        pending = 1 + int'($urandom % 4);
      end else if (pending > 0) begin
        pending--;
        if (pending == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data = (nreq == 1) ? e1 : e2;
        end
      end
      @(negedge clk);
    end
    if (!got) chk(1'b0, "R7 walk finished", 32'd0, 32'd1);
    chk(done === 1'b0 && busy === 1'b0 && mem_req_valid === 1'b0,
        "R8 R7 idle after result", {29'd0, done, busy, mem_req_valid}, 32'd0);
    mem_resp_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [31:0] r, input bit v, input bit res, input bit leaf);
    return {r[31:3], leaf, res, v};
  endfunction

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0,
        "R1 reset state", {29'd0, busy, done, mem_req_valid}, 32'd0);
    // R8 stray response while idle
    mem_resp_valid = 1'b1; mem_resp_data = 32'hFFFF_FFFF;
    @(negedge clk);
    mem_resp_valid = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0,
        "R8 idle stray response", {29'd0, busy, done, mem_req_valid}, 32'd0);
    // R4 small page success; L2 leaf bit ignored
    walk(20'hABCDE, 32'h0010_0000, mk(32'h1234_5000, 1, 1, 0), mk(32'h8765_4FF8, 1, 1, 0), 0);
    walk(20'h00001, 32'h0020_0000, mk(32'h0000_3000, 1, 1, 0), mk(32'h4444_4038, 1, 1, 1), 0);
    // R5 large page
    walk(20'h3FFFF, 32'h0030_0000, mk(32'hFFC0_0128, 1, 1, 1), 32'hDEAD_BEEF, 0);
    // R6 faults at each level
    walk(20'h12345, 32'h0040_0000, mk(32'h5555_5000, 0, 1, 0), 32'h0, 0);
    walk(20'h54321, 32'h0040_0000, mk(32'h5555_5000, 1, 0, 1), 32'h0, 0);
    walk(20'h0F0F0, 32'h0050_0000, mk(32'h6666_6000, 1, 1, 0), mk(32'h7777_7FF8, 0, 1, 0), 0);
    walk(20'hF0F0F, 32'h0050_0000, mk(32'h6666_6000, 1, 1, 0), mk(32'h7777_7FF8, 1, 0, 0), 0);
    // R7 R8 misses while busy and stray responses
    walk(20'h13579, 32'hFFFF_F000, mk(32'h2468_A000, 1, 1, 0), mk(32'h1357_9FF8, 1, 1, 0), 1);
    walk(20'h2468A, 32'h0000_1000, mk(32'hFFC0_3FF8, 1, 1, 1), 32'h0, 1);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      walk(20'($urandom), $urandom,
           mk(r1, ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 3) == 0),
           mk(r2, ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 2) == 0),
           ($urandom % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule